// File: doc/BRIEF.md
# Flash Program/Erase Status Sequencer

This block is a behavioural controller for a small embedded flash array. It sits behind an asynchronous-style memory bus made of active-low chip enable, output enable and write enable, plus an address and a 16-bit data path. Bus strobes are recognised on the system clock. Writes are decoded as unlock-and-command sequences that start timed word programs, sector erases or a chip erase against an internal register array. While an operation runs, progress is visible in three ways at the same time: an inverted data bit, a bit that alternates on every read, and an active-low busy pin.

The array is split into four equal sectors. The lowest sector is the boot sector, and a command can lock it against change. A digital high-voltage override input lifts that lock for the operation it accompanies. A dedicated flash reset input aborts work in progress and turns off the data drivers. A direct-write mode programs each write strobe without any preamble. Only a long enough pulse on the flash reset input, or the system reset, ends that mode.

Top module: `flash_status_seq`

## Requirements
- R1: After `rst`, `busy_n` is 1, no command or direct-write mode is active, the boot lock is clear, and every array word reads 0xFFFF.
- R2: A write strobe is a falling `we_n` with `ce_n` low and `oe_n` high. A read strobe is a falling `oe_n` with `ce_n` low, and it loads `rdata` at that clock edge. The write sequence 0x00AA at address 0x15, 0x0055 at 0x0A and 0x00A0 at 0x15, followed by data D at address X, stores D at X when the program operation completes. Later reads of X return D.
- R3: `busy_n` goes low at the edge of the write that starts an operation. It stays low for PROG_CYC cycles for a program and ERASE_CYC cycles for an erase, then returns high.
- R4: While busy, a read at any address returns a status word. In that word, bits 15:8 and 5:0 are 0. Bit 7 is the inverse of bit 7 of the data being programmed, or 0 during an erase. Bit 6 holds a toggle value that starts at 0 after reset and inverts after each busy read. When idle, reads return array data and the toggle does not change.
- R5: The sequence 0xAA@0x15, 0x55@0x0A, 0x80@0x15, 0xAA@0x15, 0x55@0x0A followed by 0x30 at any address erases to 0xFFFF the sector selected by address bits [AW-1:AW-2]. Following the same five writes with 0x10@0x15 erases every sector.
- R6: The writes 0xAA@0x15, 0x55@0x0A, 0x40@0x15 set the boot lock, which stays set until `rst`. While it is set, a program or sector erase aimed at sector 0 and any chip erase are ignored: `busy_n` stays high and the contents do not change.
- R7: When `hv_override` is high during the final write of a program, sector erase or chip erase, the boot lock does not block that operation.
- R8: A write that does not match the next expected step of a sequence returns the decoder to read mode. A data write that follows it is not programmed.
- R9: Write strobes that arrive while busy are ignored and do not advance the command decoder.
- R10: While `flash_rst_n` is low, `data_oe` is 0 and no strobe is accepted. The running operation is abandoned: `busy_n` is high by the next cycle and the target word keeps its old value.
- R11: The writes 0xAA@0x15, 0x55@0x0A, 0x80@0x15, 0xA0@0x15 enter direct-write mode. In this mode each write strobe taken while idle starts a program of the addressed word.
- R12: Direct-write mode ends only on `rst`, or when `flash_rst_n` rises after at least RST_MIN_CYC clock edges low. A shorter low pulse keeps the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| flash_rst_n | input | 1 | Active-low flash reset: abort and output disable |
| hv_override | input | 1 | Boot-lock override level, sampled on the final command write |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | AW | Word address |
| wdata | input | 16 | Write data and command codes (low byte) |
| rdata | output | 16 | Read data or status word, loaded on a read strobe |
| data_oe | output | 1 | High while the data bus would be driven |
| busy_n | output | 1 | Active-low busy for program and erase |

## Verification
Programs are tried with data whose bit 7 is both 1 and 0, so the inverted polling bit can be told apart from a constant or true-data bit. Two back-to-back busy reads separate a real toggle from a stuck bit. Erase is tried by sector and on the whole chip. The boot sector is targeted both with and without the override, which shows the lock as distinct from a broken command path. Broken sequences, writes during busy, a mid-operation abort, and short and long reset pulses in direct-write mode each show whether a stray write could start or change an operation.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PROG,
        OP_SERASE,
        OP_CERASE
    } op_kind_t;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_UNL1,
        CS_UNL2,
        CS_PDATA,
        CS_ESET,
        CS_EUNL1,
        CS_EUNL2
    } cmd_state_t;

    typedef struct packed {
        op_kind_t    kind;
        logic [15:0] data;
    } op_req_t;

    localparam logic [7:0]  KEY_A      = 8'hAA;
    localparam logic [7:0]  KEY_B      = 8'h55;
    localparam logic [7:0]  CODE_PROG  = 8'hA0;
    localparam logic [7:0]  CODE_ESET  = 8'h80;
    localparam logic [7:0]  CODE_LOCK  = 8'h40;
    localparam logic [7:0]  CODE_SECT  = 8'h30;
    localparam logic [7:0]  CODE_CHIP  = 8'h10;
    localparam logic [11:0] UNLOCK_LO  = 12'h555;
    localparam logic [11:0] UNLOCK_HI  = 12'h2AA;

    function automatic logic is_erase(input op_kind_t k);
        return (k == OP_SERASE) || (k == OP_CERASE);
    endfunction

endpackage

// File: rtl/cmd_decoder.sv
module cmd_decoder
    import flash_seq_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          wr_stb,
    input  logic          busy,
    input  logic          spm,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   wdata,
    output op_req_t       req,
    output logic          lock_set,
    output logic          spm_set,
    output cmd_state_t    state
);
    localparam logic [AW-1:0] UA1 = AW'(UNLOCK_LO);
    localparam logic [AW-1:0] UA2 = AW'(UNLOCK_HI);

    cmd_state_t nxt;
    logic       at1, at2;
    logic [7:0] code;

    assign at1  = (addr == UA1);
    assign at2  = (addr == UA2);
    assign code = wdata[7:0];

    always_comb begin
        nxt      = state;
        req      = '0;
        lock_set = 1'b0;
        spm_set  = 1'b0;
        if (wr_stb && !busy) begin
            nxt = CS_IDLE;
            if (spm) begin
                req = '{kind: OP_PROG, data: wdata};
            end else begin
                case (state)
                    CS_IDLE:  if (at1 && code == KEY_A) nxt = CS_UNL1;
                    CS_UNL1:  if (at2 && code == KEY_B) nxt = CS_UNL2;
                    CS_UNL2: begin
                        if (at1 && code == CODE_PROG)      nxt = CS_PDATA;
                        else if (at1 && code == CODE_ESET) nxt = CS_ESET;
                        else if (at1 && code == CODE_LOCK) lock_set = 1'b1;
                    end
                    CS_PDATA: req = '{kind: OP_PROG, data: wdata};
                    CS_ESET: begin
                        if (at1 && code == KEY_A)          nxt = CS_EUNL1;
                        else if (at1 && code == CODE_PROG) spm_set = 1'b1;
                    end
                    CS_EUNL1: if (at2 && code == KEY_B) nxt = CS_EUNL2;
                    CS_EUNL2: begin
                        if (code == CODE_SECT)
                            req = '{kind: OP_SERASE, data: 16'hFFFF};
                        else if (at1 && code == CODE_CHIP)
                            req = '{kind: OP_CERASE, data: 16'hFFFF};
                    end
                    default: nxt = CS_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) state <= CS_IDLE;
        else              state <= nxt;
    end
endmodule

// File: rtl/op_timer.sv
module op_timer
    import flash_seq_pkg::*;
#(
    parameter int AW        = 5,
    parameter int PROG_CYC  = 12,
    parameter int ERASE_CYC = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          abort,
    input  logic          launch,
    input  op_req_t       req,
    input  logic [AW-1:0] req_addr,
    output logic          busy,
    output logic          done,
    output op_req_t       cur,
    output logic [AW-1:0] cur_addr
);
    localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_q;

    assign done = busy && (cnt_q == '0) && !abort;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy     <= 1'b0;
            cnt_q    <= '0;
            cur      <= '0;
            cur_addr <= '0;
        end else if (launch) begin
            busy     <= 1'b1;
            cnt_q    <= is_erase(req.kind) ? CW'(ERASE_CYC - 1) : CW'(PROG_CYC - 1);
            cur      <= req;
            cur_addr <= req_addr;
        end else if (busy) begin
            if (cnt_q == '0) busy  <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/word_array.sv
module word_array
    import flash_seq_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          commit,
    input  op_req_t       op,
    input  logic [AW-1:0] op_addr,
    input  logic [AW-1:0] raddr,
    output logic [15:0]   rword
);
    localparam int WORDS = 1 << AW;

    logic [15:0] cells [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_cell
        localparam logic [1:0]    SEC = 2'(i >> (AW - 2));
        localparam logic [AW-1:0] ADR = AW'(i);
        logic [15:0] cell_q;
        logic        hit;

        always_comb begin
            case (op.kind)
                OP_PROG:   hit = (op_addr == ADR);
                OP_SERASE: hit = (op_addr[AW-1:AW-2] == SEC);
                OP_CERASE: hit = 1'b1;
                default:   hit = 1'b0;
            endcase
        end

        always_ff @(posedge clk) begin
            if (rst)               cell_q <= 16'hFFFF;
            else if (commit && hit) cell_q <= op.data;
        end

        assign cells[i] = cell_q;
    end

    assign rword = cells[raddr];
endmodule

// File: rtl/flash_status_seq.sv
module flash_status_seq
    import flash_seq_pkg::*;
#(
    parameter int AW          = 5,
    parameter int PROG_CYC    = 12,
    parameter int ERASE_CYC   = 24,
    parameter int RST_MIN_CYC = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flash_rst_n,
    input  logic          hv_override,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   wdata,
    output logic [15:0]   rdata,
    output logic          data_oe,
    output logic          busy_n
);
    localparam int LCW = $clog2(RST_MIN_CYC + 1);

    logic            oe_prev_q, we_prev_q, frst_prev_q;
    logic            wr_stb, rd_stb;
    logic            lock_q, spm_q, tog_q;
    logic [LCW-1:0]  low_cnt_q;
    logic [15:0]     rdata_q, rword, status;
    op_req_t         req, cur;
    logic [AW-1:0]   cur_addr;
    logic            lock_set, spm_set, busy, done, launch, blocked, tgt_boot;
    cmd_state_t      dec_state;

    assign wr_stb = flash_rst_n && !ce_n && oe_n && !we_n && we_prev_q;
    assign rd_stb = flash_rst_n && !ce_n && !oe_n && oe_prev_q;

    cmd_decoder #(.AW(AW)) i_dec (
        .clk(clk), .rst(rst), .flush(!flash_rst_n), .wr_stb(wr_stb),
        .busy(busy), .spm(spm_q), .addr(addr), .wdata(wdata),
        .req(req), .lock_set(lock_set), .spm_set(spm_set), .state(dec_state)
    );

    assign tgt_boot = (req.kind == OP_CERASE) || (addr[AW-1:AW-2] == 2'b00);
    assign blocked  = lock_q && !hv_override && tgt_boot;
    assign launch   = (req.kind != OP_NONE) && !blocked;

    op_timer #(.AW(AW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) i_tmr (
        .clk(clk), .rst(rst), .abort(!flash_rst_n), .launch(launch),
        .req(req), .req_addr(addr), .busy(busy), .done(done),
        .cur(cur), .cur_addr(cur_addr)
    );

    word_array #(.AW(AW)) i_arr (
        .clk(clk), .rst(rst), .commit(done), .op(cur), .op_addr(cur_addr),
        .raddr(addr), .rword(rword)
    );

    assign status = {8'h00, (cur.kind == OP_PROG) ? ~cur.data[7] : 1'b0, tog_q, 6'h00};

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_prev_q   <= 1'b1;
            we_prev_q   <= 1'b1;
            frst_prev_q <= 1'b1;
            low_cnt_q   <= '0;
            lock_q      <= 1'b0;
            spm_q       <= 1'b0;
            tog_q       <= 1'b0;
            rdata_q     <= '0;
        end else begin
            oe_prev_q   <= oe_n;
            we_prev_q   <= we_n;
            frst_prev_q <= flash_rst_n;
            if (flash_rst_n)                          low_cnt_q <= '0;
            else if (low_cnt_q != LCW'(RST_MIN_CYC))  low_cnt_q <= low_cnt_q + 1'b1;
            if (lock_set) lock_q <= 1'b1;
            if (spm_set)
                spm_q <= 1'b1;
            else if (flash_rst_n && !frst_prev_q && low_cnt_q == LCW'(RST_MIN_CYC))
                spm_q <= 1'b0;
            if (rd_stb) begin
                rdata_q <= busy ? status : rword;
                if (busy) tog_q <= ~tog_q;
            end
        end
    end

    assign rdata   = rdata_q;
    assign data_oe = flash_rst_n && !ce_n && !oe_n;
    assign busy_n  = !busy;
endmodule

// File: rtl/flash_status_seq_chk.sv
module flash_status_seq_chk
    import flash_seq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       flash_rst_n,
    input logic       frst_prev,
    input logic       busy_n,
    input logic       wr_stb,
    input logic       tog,
    input logic       spm,
    input cmd_state_t dec_state
);
    assert_read_mode_after_reset_R1: assert property (@(posedge clk)
        rst |=> (dec_state == CS_IDLE) && !spm && busy_n);

    assert_busy_from_write_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_n) |-> $past(wr_stb));

    assert_toggle_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        busy_n |=> $stable(tog));

    assert_ignore_while_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy_n && wr_stb) |=> $stable(dec_state));

    assert_abort_releases_R10: assert property (@(posedge clk) disable iff (rst)
        !flash_rst_n |=> busy_n);

    assert_spm_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        (spm && flash_rst_n && frst_prev) |=> spm);
endmodule

bind flash_status_seq flash_status_seq_chk i_chk (
    .clk(clk), .rst(rst), .flash_rst_n(flash_rst_n), .frst_prev(frst_prev_q),
    .busy_n(busy_n), .wr_stb(wr_stb), .tog(tog_q), .spm(spm_q), .dec_state(dec_state)
);

// File: tb/test_flash_status_seq.sv
module test_flash_status_seq;
    localparam int AW = 5, PROG_CYC = 12, ERASE_CYC = 24, RST_MIN_CYC = 7;
    localparam logic [AW-1:0] A1 = 5'h15, A2 = 5'h0A;

    logic clk = 1'b0, rst = 1'b1, flash_rst_n = 1'b1, hv_override = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0] wdata = '0;
    wire  [15:0] rdata;
    wire         data_oe, busy_n;

    int total = 0, bad = 0;
    logic tog_m = 1'b0;
    logic rd_pending = 1'b0;

    typedef struct { logic [15:0] exp; string tag; } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    flash_status_seq #(.AW(AW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
                       .RST_MIN_CYC(RST_MIN_CYC)) i_flash_status_seq (
        .clk(clk), .rst(rst), .flash_rst_n(flash_rst_n), .hv_override(hv_override),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .data_oe(data_oe), .busy_n(busy_n)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data and compares at the negedge after the strobe edge
    always @(negedge clk) begin
        if (rd_pending) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, rdata, e.exp);
            rd_pending = 1'b0;
        end
    end

    task automatic wr(logic [AW-1:0] a, logic [15:0] d);
        @(negedge clk); addr = a; wdata = d; ce_n = 0; we_n = 0;
        @(negedge clk); we_n = 1; ce_n = 1;
    endtask

    task automatic rd(logic [AW-1:0] a, logic [15:0] exp, string tag);
        exp_t e;
        @(negedge clk); addr = a; ce_n = 0; oe_n = 0;
        @(posedge clk);
        e.exp = exp; e.tag = tag;
        sb.push_back(e);
        rd_pending = 1'b1;
        @(negedge clk); #1; oe_n = 1; ce_n = 1;
    endtask

    task automatic rd_status(logic b7, string tag);
        rd(A2, {8'h00, b7, tog_m, 6'h00}, tag);
        tog_m = ~tog_m;
    endtask

    task automatic unlock; wr(A1, 16'h00AA); wr(A2, 16'h0055); endtask
    task automatic prog(logic [AW-1:0] a, logic [15:0] d);
        unlock; wr(A1, 16'h00A0); wr(a, d);
    endtask
    task automatic erase_pre; unlock; wr(A1, 16'h0080); unlock; endtask
    task automatic sect_erase(logic [AW-1:0] a); erase_pre; wr(a, 16'h0030); endtask
    task automatic chip_erase; erase_pre; wr(A1, 16'h0010); endtask
    task automatic idle(int n); repeat (n) @(negedge clk); endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3); rst = 0; idle(1);
        // R1 reset state
        check("R1 busy_n after reset", 16'(busy_n), 16'h1);
        check("R1 data_oe idle", 16'(data_oe), 16'h0);
        rd(5'd3, 16'hFFFF, "R1 erased after reset");

        // R2/R3/R4 program with data bit7=1
        prog(5'd9, 16'h12C5);
        check("R3 busy_n low at start", 16'(busy_n), 16'h0);
        rd_status(1'b0, "R4 status read 1");
        rd_status(1'b0, "R4 status read 2 toggled");
        idle(PROG_CYC - 6);
        check("R3 busy_n low at end of window", 16'(busy_n), 16'h0);
        idle(2);
        check("R3 busy_n released", 16'(busy_n), 16'h1);
        rd(5'd9, 16'h12C5, "R2 programmed word");
        rd(5'd9, 16'h12C5, "R4 idle read no toggle");

        // R4 program with data bit7=0
        prog(5'd10, 16'h0033);
        rd_status(1'b1, "R4 inverted bit7");
        idle(PROG_CYC + 1);
        rd(5'd10, 16'h0033, "R2 second word");

        // R5 sector erase of sector 1
        sect_erase(5'd12);
        check("R3 busy_n erase", 16'(busy_n), 16'h0);
        rd_status(1'b0, "R4 erase status");
        idle(ERASE_CYC + 1);
        check("R3 erase released", 16'(busy_n), 16'h1);
        rd(5'd9, 16'hFFFF, "R5 sector erased a");
        rd(5'd10, 16'hFFFF, "R5 sector erased b");

        // R6/R7 boot lock
        prog(5'd2, 16'hABCD); idle(PROG_CYC + 1);
        unlock; wr(A1, 16'h0040);
        prog(5'd3, 16'h1111);
        check("R6 locked program ignored", 16'(busy_n), 16'h1);
        rd(5'd3, 16'hFFFF, "R6 locked word unchanged");
        sect_erase(5'd1);
        check("R6 locked erase ignored", 16'(busy_n), 16'h1);
        rd(5'd2, 16'hABCD, "R6 boot data kept");
        chip_erase;
        check("R6 locked chip erase ignored", 16'(busy_n), 16'h1);
        rd(5'd2, 16'hABCD, "R6 boot data kept after chip erase");
        hv_override = 1; prog(5'd3, 16'h1111); hv_override = 0;
        check("R7 override starts program", 16'(busy_n), 16'h0);
        idle(PROG_CYC + 1);
        rd(5'd3, 16'h1111, "R7 override programmed");

        // R8 broken sequence
        unlock; wr(A1, 16'h0077); wr(5'd20, 16'h5555);
        check("R8 no program after bad code", 16'(busy_n), 16'h1);
        rd(5'd20, 16'hFFFF, "R8 word untouched");

        // R9 writes during busy
        prog(5'd17, 16'h0F0F);
        wr(5'd18, 16'h3C3C);
        unlock; wr(A1, 16'h00A0);
        idle(PROG_CYC);
        wr(5'd19, 16'h5A5A);
        check("R9 decoder not advanced by busy writes", 16'(busy_n), 16'h1);
        rd(5'd18, 16'hFFFF, "R9 busy write ignored");
        rd(5'd17, 16'h0F0F, "R9 running op completed");

        // R10 abort
        prog(5'd21, 16'h0001);
        idle(3);
        flash_rst_n = 0; ce_n = 0; oe_n = 0;
        idle(1);
        check("R10 busy released on abort", 16'(busy_n), 16'h1);
        check("R10 outputs off", 16'(data_oe), 16'h0);
        oe_n = 1; ce_n = 1; idle(1); flash_rst_n = 1;
        idle(PROG_CYC + 1);
        check("R10 no late busy", 16'(busy_n), 16'h1);
        rd(5'd21, 16'hFFFF, "R10 aborted word unchanged");

        // R11 direct write mode
        unlock; wr(A1, 16'h0080); wr(A1, 16'h00A0);
        wr(5'd24, 16'h00AA);
        check("R11 direct write busy", 16'(busy_n), 16'h0);
        idle(PROG_CYC + 1);
        rd(5'd24, 16'h00AA, "R11 direct word a");
        wr(5'd25, 16'h0055); idle(PROG_CYC + 1);
        rd(5'd25, 16'h0055, "R11 direct word b");

        // R12 short pulse keeps mode, long pulse ends it
        flash_rst_n = 0; idle(2); flash_rst_n = 1; idle(1);
        wr(5'd26, 16'h1234);
        check("R12 short pulse keeps mode", 16'(busy_n), 16'h0);
        idle(PROG_CYC + 1);
        rd(5'd26, 16'h1234, "R12 word after short pulse");
        flash_rst_n = 0; idle(RST_MIN_CYC + 3); flash_rst_n = 1; idle(1);
        wr(5'd27, 16'h4321);
        check("R12 long pulse ends mode", 16'(busy_n), 16'h1);
        rd(5'd27, 16'hFFFF, "R12 no direct write after exit");

        // R1 reset again, R5 chip erase
        rst = 1; idle(2); rst = 0; tog_m = 0; idle(1);
        rd(5'd2, 16'hFFFF, "R1 array cleared by reset");
        prog(5'd30, 16'h0000); idle(PROG_CYC + 1);
        prog(5'd4, 16'h0101); idle(PROG_CYC + 1);
        chip_erase;
        check("R5 chip erase busy", 16'(busy_n), 16'h0);
        idle(ERASE_CYC + 1);
        rd(5'd30, 16'hFFFF, "R5 chip erase upper");
        rd(5'd4, 16'hFFFF, "R5 chip erase boot");

        idle(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule